// File: doc/BRIEF.md
# Bus-Master DMA Channel Status Register Pair

This block holds the 8-bit status register of a bus-master DMA controller for two channels, a primary and a secondary. Each register can be reached through a byte-wide register port at a fixed offset from the block's base address. Each register mixes four kinds of bit:

- event flags that hardware sets and software clears by writing a one,
- two capability bits that software reads and writes and that nothing inside the block uses,
- two reserved bits that always read as zero,
- a read-only activity flag that follows the start bit of the companion command register.

The DMA engine and the link layer deliver single-cycle event pulses to each channel: a descriptor completion together with its interrupt-request flag, a received device frame together with its interrupt bit, a bus abort, and completion of the end-of-table region. They also deliver the level of the start bit and the level of the interrupt-enable control. Each channel drives an interrupt line from its two interrupt-type flags.

Top module: `bmdma_status_regs`

## Requirements
- R1: After synchronous reset, both registers read 00h and both interrupt outputs are low.
- R2: The primary register is decoded at offset 02h and the secondary at offset 0Ah. Reads of any other offset return 00h, and writes to any other offset change neither register.
- R3: Bit 7 is set in the cycle after a descriptor-completion pulse whose interrupt flag is high. A completion whose interrupt flag is low leaves bit 7 unchanged.
- R4: Bit 2 is set in the cycle after a received-frame pulse whose interrupt bit is high, but only if the interrupt-enable input is high in that cycle.
- R5: Bit 1 is set in the cycle after a bus-abort pulse.
- R6: Writing 1 to bit 7, 2 or 1 of a decoded register clears that bit. Writing 0 to any of those bits leaves it unchanged.
- R7: When a hardware set event and a write-1 clear reach the same flag in the same cycle, the flag ends the cycle set.
- R8: Bits 6 and 5 take the written value on every decoded write, read back unchanged, and affect no other bit and no interrupt output.
- R9: Bits 4 and 3 always read 0, whatever was written to them.
- R10: Bit 0 is set in the cycle after the start-bit level rises. Software writes to bit 0 have no effect.
- R11: Bit 0 is cleared in the cycle after an end-of-table completion pulse or a fall of the start-bit level. If a start rise and an end-of-table pulse arrive in the same cycle, bit 0 ends set.
- R12: The interrupt output of a channel is high exactly when bit 2 or bit 7 of that channel's register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (8) | Register offset from the block base |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rdata | output | 8 | Read data for the addressed offset (combinational) |
| desc_done | input | NUM_CH (2) | Descriptor execution finished, one pulse per channel |
| desc_irq_flag | input | NUM_CH (2) | Interrupt flag of the finished descriptor |
| frame_rx | input | NUM_CH (2) | Device frame received, one pulse per channel |
| frame_irq_bit | input | NUM_CH (2) | Interrupt bit carried by the received frame |
| irq_enable | input | NUM_CH (2) | Interrupt-enable control level, high means enabled |
| bus_abort | input | NUM_CH (2) | Target or master abort during a data transfer |
| eot_done | input | NUM_CH (2) | Last transfer of an end-of-table region completed |
| start_level | input | NUM_CH (2) | Start bit of the companion command register |
| irq_out | output | NUM_CH (2) | Per-channel interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, two channels, and the channels decoded at 02h and 0Ah. The 8-bit offset space lets random accesses land on undecoded offsets, so R2 is exercised. Because the two channels are decoded close together, a write to one channel can be shown to leave the other unchanged. Random event pulses, start-level toggles and mixed write data push the two channels through overlapping set, clear and start transitions. Directed cases then force the same-cycle collisions that random stimulus seldom produces.

// File: rtl/bmdma_status_pkg.sv
package bmdma_status_pkg;

    localparam int STAT_W = 8;

    typedef struct packed {
        logic       desc_int;   // bit 7
        logic       cap_drv1;   // bit 6
        logic       cap_drv0;   // bit 5
        logic [1:0] rsv;        // bits 4:3
        logic       dev_int;    // bit 2
        logic       abort_err;  // bit 1
        logic       active;     // bit 0
    } chan_stat_t;

    typedef struct packed {
        logic desc_done;
        logic desc_irq_flag;
        logic frame_rx;
        logic frame_irq_bit;
        logic irq_enable;
        logic bus_abort;
        logic eot_done;
        logic start_level;
    } chan_evt_t;

    // Offset of each channel's register from the block base
    function automatic int unsigned chan_offset(input int unsigned idx,
                                                input int unsigned pri_ofs,
                                                input int unsigned stride);
        return pri_ofs + idx * stride;
    endfunction

endpackage

// File: rtl/bmdma_w1c_flag.sv
module bmdma_w1c_flag (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic sw_clr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (hw_set) flag_q <= 1'b1;
        else if (sw_clr) flag_q <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> flag_q);
    assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && !hw_set) |=> !flag_q);
    assert_w1c_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!sw_clr && !hw_set) |=> $stable(flag_q));
endmodule

// File: rtl/bmdma_chan_status.sv
module bmdma_chan_status
    import bmdma_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    input  chan_evt_t         evt,
    output chan_stat_t        stat,
    output logic              irq
);
    chan_stat_t wbits;
    logic set_desc, set_dev, set_err;
    logic start_q, start_rise, start_fall;
    logic cap1_q, cap0_q, act_q;
    logic desc_q, dev_q, err_q;

    assign wbits      = chan_stat_t'(wdata);
    assign set_desc   = evt.desc_done && evt.desc_irq_flag;
    assign set_dev    = evt.frame_rx && evt.frame_irq_bit && evt.irq_enable;
    assign set_err    = evt.bus_abort;
    assign start_rise = evt.start_level && !start_q;
    assign start_fall = !evt.start_level && start_q;

    bmdma_w1c_flag u_desc (.clk(clk), .rst(rst), .hw_set(set_desc),
                           .sw_clr(wr_en && wbits.desc_int), .flag_q(desc_q));
    bmdma_w1c_flag u_dev  (.clk(clk), .rst(rst), .hw_set(set_dev),
                           .sw_clr(wr_en && wbits.dev_int), .flag_q(dev_q));
    bmdma_w1c_flag u_err  (.clk(clk), .rst(rst), .hw_set(set_err),
                           .sw_clr(wr_en && wbits.abort_err), .flag_q(err_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            act_q   <= 1'b0;
            cap1_q  <= 1'b0;
            cap0_q  <= 1'b0;
        end else begin
            start_q <= evt.start_level;
            if (start_rise)                   act_q <= 1'b1;
            else if (start_fall || evt.eot_done) act_q <= 1'b0;
            if (wr_en) begin
                cap1_q <= wbits.cap_drv1;
                cap0_q <= wbits.cap_drv0;
            end
        end
    end

    always_comb begin
        stat           = '0;
        stat.desc_int  = desc_q;
        stat.cap_drv1  = cap1_q;
        stat.cap_drv0  = cap0_q;
        stat.dev_int   = dev_q;
        stat.abort_err = err_q;
        stat.active    = act_q;
    end

    assign irq = desc_q || dev_q;

    assert_act_rise_R10: assert property (@(posedge clk) disable iff (rst)
        start_rise |=> stat.active);
    assert_act_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (!start_rise && (start_fall || evt.eot_done)) |=> !stat.active);
    assert_act_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!start_rise && !start_fall && !evt.eot_done) |=> $stable(stat.active));
    assert_rsv_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[4:3] != 2'b00) |=> stat.rsv == 2'b00);
    assert_cap_write_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> {stat.cap_drv1, stat.cap_drv0} == $past(wdata[6:5]));
    assert_desc_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (evt.desc_done && !evt.desc_irq_flag && !wr_en && !stat.desc_int)
        |=> !stat.desc_int);
    assert_dev_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.frame_rx && evt.frame_irq_bit && !evt.irq_enable && !wr_en && !stat.dev_int)
        |=> !stat.dev_int);
endmodule

// File: rtl/bmdma_status_regs.sv
module bmdma_status_regs
    import bmdma_status_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_CH  = 2,
    parameter int PRI_OFS = 2,
    parameter int CH_STEP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] desc_done,
    input  logic [NUM_CH-1:0] desc_irq_flag,
    input  logic [NUM_CH-1:0] frame_rx,
    input  logic [NUM_CH-1:0] frame_irq_bit,
    input  logic [NUM_CH-1:0] irq_enable,
    input  logic [NUM_CH-1:0] bus_abort,
    input  logic [NUM_CH-1:0] eot_done,
    input  logic [NUM_CH-1:0] start_level,
    output logic [NUM_CH-1:0] irq_out
);
    chan_stat_t        stat   [NUM_CH];
    logic [NUM_CH-1:0] hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] OFS =
            ADDR_W'(chan_offset(c, PRI_OFS, CH_STEP));
        chan_evt_t evt;

        assign hit[c] = (reg_addr == OFS);
        assign evt = '{desc_done:     desc_done[c],
                       desc_irq_flag: desc_irq_flag[c],
                       frame_rx:      frame_rx[c],
                       frame_irq_bit: frame_irq_bit[c],
                       irq_enable:    irq_enable[c],
                       bus_abort:     bus_abort[c],
                       eot_done:      eot_done[c],
                       start_level:   start_level[c]};

        bmdma_chan_status u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr_en (reg_wr && hit[c]),
            .wdata (reg_wdata),
            .evt   (evt),
            .stat  (stat[c]),
            .irq   (irq_out[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (hit[c]) reg_rdata = stat[c];
    end

    assert_decode_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));
    assert_irq_track_R12: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[7] || reg_rdata[2]) && hit != '0 |-> (irq_out & hit) != '0);
endmodule

// File: tb/bmdma_status_regs_tb_top.sv
module bmdma_status_regs_tb_top;
    localparam int NCH = 2;

    logic clk = 0;
    logic rst = 1;
    logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
    logic reg_wr = 0;
    logic [NCH-1:0] desc_done = 0, desc_irq_flag = 0, frame_rx = 0, frame_irq_bit = 0;
    logic [NCH-1:0] irq_enable = 0, bus_abort = 0, eot_done = 0, start_level = 0, irq_out;

    int unsigned n_vec = 0, n_bad = 0;
    logic [7:0] mdl [NCH];
    logic [NCH-1:0] mstart = 0;

    always #2 clk = ~clk;

    bmdma_status_regs dut_i (.*);

    function automatic int ch_of(input logic [7:0] a);
        if (a == 8'h02) return 0;
        if (a == 8'h0A) return 1;
        return -1;
    endfunction

    function automatic logic [7:0] nxt(input logic [7:0] cur, input logic wr, input logic [7:0] wd,
            input logic dd, input logic df, input logic fr, input logic fb, input logic en,
            input logic ab, input logic eo, input logic st, input logic pst);
        logic [7:0] n = cur;
        if (wr) begin
            n[6:5] = wd[6:5];
            if (wd[7]) n[7] = 0;
            if (wd[2]) n[2] = 0;
            if (wd[1]) n[1] = 0;
        end
        if (dd && df) n[7] = 1;
        if (fr && fb && en) n[2] = 1;
        if (ab) n[1] = 1;
        if (st && !pst) n[0] = 1;
        else if ((!st && pst) || eo) n[0] = 0;
        n[4:3] = 0;
        return n;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply the currently driven inputs for one edge, update model, check
    task automatic step(input string req);
        int c;
        @(posedge clk);
        #1;
        c = ch_of(reg_addr);
        for (int k = 0; k < NCH; k++) begin
            mdl[k] = nxt(mdl[k], reg_wr && c == k, reg_wdata, desc_done[k], desc_irq_flag[k],
                         frame_rx[k], frame_irq_bit[k], irq_enable[k], bus_abort[k],
                         eot_done[k], start_level[k], mstart[k]);
            mstart[k] = start_level[k];
        end
        chk(req, reg_rdata, (c < 0) ? 8'h00 : mdl[c]);
        for (int k = 0; k < NCH; k++)
            chk({req, " R12 irq"}, irq_out[k], mdl[k][7] | mdl[k][2]);
        @(negedge clk);
        reg_wr = 0; desc_done = 0; frame_rx = 0; bus_abort = 0; eot_done = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int k = 0; k < NCH; k++) mdl[k] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(8'h02, 8'h00, "R1 primary reset");
        rd(8'h0A, 8'h00, "R1 secondary reset");
        chk("R1 irq reset", irq_out, 0);
        // R9 reserved bits, R8 capability bits, R10 write to bit 0
        reg_addr = 8'h02; reg_wdata = 8'h79; reg_wr = 1; step("R8 R9 R10 write");
        rd(8'h02, 8'h60, "R9 reserved zero, R8 caps");
        chk("R8 no irq", irq_out, 0);
        // R2 undecoded write
        reg_addr = 8'h06; reg_wdata = 8'hFF; reg_wr = 1; step("R2 undecoded");
        rd(8'h0A, 8'h00, "R2 secondary untouched");
        rd(8'h02, 8'h60, "R2 primary untouched");
        // R3 gating and set
        desc_done[0] = 1; desc_irq_flag[0] = 0; step("R3 no flag");
        rd(8'h02, 8'h60, "R3 flag low no set");
        desc_done[0] = 1; desc_irq_flag[0] = 1; step("R3 set");
        rd(8'h02, 8'hE0, "R3 bit7 set");
        // R4 gating
        reg_addr = 8'h0A; frame_rx[1] = 1; frame_irq_bit[1] = 1; irq_enable[1] = 0; step("R4 disabled");
        rd(8'h0A, 8'h00, "R4 disabled no set");
        frame_rx[1] = 1; irq_enable[1] = 1; step("R4 set");
        rd(8'h0A, 8'h04, "R4 bit2 set");
        // R5
        bus_abort[1] = 1; step("R5 abort");
        rd(8'h0A, 8'h06, "R5 bit1 set");
        // R6 write zeros keep, write ones clear
        reg_addr = 8'h0A; reg_wdata = 8'h00; reg_wr = 1; step("R6 write0");
        rd(8'h0A, 8'h06, "R6 zero keeps");
        reg_wdata = 8'h02; reg_wr = 1; step("R6 clear bit1");
        rd(8'h0A, 8'h04, "R6 bit1 cleared");
        // R7 collision
        reg_wdata = 8'h04; reg_wr = 1; frame_rx[1] = 1; step("R7 collide");
        rd(8'h0A, 8'h04, "R7 set wins");
        // R10/R11 start
        start_level[0] = 1; reg_addr = 8'h02; step("R10 rise");
        rd(8'h02, 8'hE1, "R10 active set");
        eot_done[0] = 1; step("R11 eot");
        rd(8'h02, 8'hE0, "R11 eot clears");
        start_level[0] = 0; step("R11 fall idle");
        start_level[0] = 1; eot_done[0] = 1; step("R11 rise+eot");
        rd(8'h02, 8'hE1, "R11 rise beats eot");
        start_level[0] = 0; step("R11 fall");
        rd(8'h02, 8'hE0, "R11 fall clears");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            reg_addr = (sel < 4) ? 8'h02 : (sel < 8) ? 8'h0A : 8'($urandom);
            reg_wr = ($urandom_range(0, 3) == 0);
            reg_wdata = 8'($urandom);
            for (int k = 0; k < NCH; k++) begin
                desc_done[k] = ($urandom_range(0, 7) == 0);
                desc_irq_flag[k] = 1'($urandom);
                frame_rx[k] = ($urandom_range(0, 7) == 0);
                frame_irq_bit[k] = 1'($urandom);
                irq_enable[k] = ($urandom_range(0, 3) != 0);
                bus_abort[k] = ($urandom_range(0, 15) == 0);
                eot_done[k] = ($urandom_range(0, 9) == 0);
                if ($urandom_range(0, 5) == 0) start_level[k] = ~start_level[k];
            end
            step("R3 R4 R5 R6 R7 R10 R11 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule